// File: doc/BRIEF.md
# Program Counter and Skip Sequencer

This block holds the 15-bit fetch address of a small 8-bit controller core. It works out where the next fetch begins for every kind of control transfer. The kinds are: plain fall-through, short relative hops forward or backward, jumps inside the current 4 KiB page, full-range jumps, jumps through a byte read from a table, calls, a software trap and returns. The instruction decoder presents one retiring instruction per cycle on `instValid`. With it come a transfer code, the instruction's byte length and the operand fields. The execute stage adds its condition result, and the stack supplies the popped return address. The block answers with the next fetch address, the return address to push and a suppress flag.

The core has no conditional branches. A compare instruction raises `condSkip` instead, and the next instruction is then suppressed. That instruction is still fetched for its full length, but it changes nothing except the fetch address. A direct-address prefix and the instruction it modifies count as one unit, so both are suppressed. A return-and-skip returns to the caller and suppresses the first instruction there, which lets a subroutine hand back a boolean result.

Top module: `pc_skip_seq`

## Requirements
- R1: While `rstN` is low, and on the first edge after it rises, `fetchPc` is 0x0000 and `suppress` is 0.
- R2: A retiring instruction with transfer code 0 (fall-through) that is not suppressed moves `fetchPc` to the sequential address, which is `fetchPc + instLen` modulo 2^15. `instLen` is 1, 2 or 3.
- R3: Code 1 (forward hop) loads the sequential address plus `relOffset`. An offset of 0 leaves the sequential address.
- R4: Code 2 (backward hop) loads the sequential address − 32 + `relOffset`. This is a full 15-bit add that wraps below 0x0000 and has no page limit.
- R5: Code 3 (page jump) loads `absTarget[11:0]` into bits 11:0. Bits 14:12 come from the sequential address.
- R6: Code 4 (long jump) loads all 15 bits of `absTarget`.
- R7: Code 5 (table jump) loads `tableByte` into bits 7:0. Bits 14:8 come from the sequential address.
- R8: Codes 6 (page call), 7 (long call) and 8 (software trap) raise `pushEn` in the retiring cycle with `pushAddr` equal to the sequential address. They then load the targets of codes 3 and 4 and the fixed vector 0x00FF, in that order. No other code raises `pushEn`.
- R9: Code 9 (return) loads `retAddr`.
- R10: A retiring instruction that is not suppressed and has `condSkip` high sets `suppress` for the next instruction. While `suppress` is high, a retiring instruction only advances by its length, ignores its transfer code and `condSkip`, and never raises `pushEn`.
- R11: A suppressed instruction with `isPrefix` high keeps `suppress` high, so the instruction that follows is also suppressed. A suppressed instruction with `isPrefix` low clears `suppress`.
- R12: Code 10 (return-and-skip) loads `retAddr` and sets `suppress`.
- R13: With `instValid` low, `fetchPc` and `suppress` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction retires this cycle |
| xferKind | input | 4 | Transfer code (0..10, others act as 0) |
| instLen | input | 2 | Byte length of the retiring instruction |
| relOffset | input | 5 | Offset field of a relative hop |
| absTarget | input | 15 | Absolute target operand |
| tableByte | input | 8 | Byte fetched for a table jump |
| retAddr | input | 15 | Return address popped from the stack |
| condSkip | input | 1 | Compare result requests a skip |
| isPrefix | input | 1 | Retiring instruction is a direct-address prefix |
| fetchPc | output | 15 | Address of the next fetch |
| pushAddr | output | 15 | Return address to push |
| pushEn | output | 1 | Push request |
| suppress | output | 1 | The retiring instruction is being skipped |

## Verification
On every cycle, the assertions check these behaviours: reset values, holding while idle, the length-only advance and the absence of pushes while suppressed, the prefix keeping suppression alive, the long-jump, trap and return-and-skip targets, and the sequential push address. The bench's scenarios show the address arithmetic that depends on particular values. These cases are a backward hop that wraps below zero, a page jump whose sequential address has just crossed into a new page, a table jump that keeps the upper bits, and a forward offset of zero. The scenarios also walk the full skip chains: compare, then prefix, then the modified instruction, and return-and-skip followed by a suppressed call.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [3:0] {
    XF_SEQ      = 4'd0,
    XF_REL_FWD  = 4'd1,
    XF_REL_BACK = 4'd2,
    XF_PAGE     = 4'd3,
    XF_LONG     = 4'd4,
    XF_TABLE    = 4'd5,
    XF_CALL_PG  = 4'd6,
    XF_CALL_LG  = 4'd7,
    XF_TRAP     = 4'd8,
    XF_RET      = 4'd9,
    XF_RET_SKIP = 4'd10
  } xfer_e;

  // strobes from control to datapath; all-zero selects with step high = advance
  typedef struct packed {
    logic step;
    logic relFwd;
    logic relBack;
    logic pageJmp;
    logic longJmp;
    logic tableJmp;
    logic vector;
    logic retLoad;
  } pcStrobes_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [3:0] xferKind,
  input  logic       condSkip,
  input  logic       isPrefix,
  output pcStrobes_t strobes,
  output logic       pushEn,
  output logic       skipFlag
);

  logic nextSkip;
  xfer_e kind;

  assign kind = xfer_e'(xferKind);

  always_comb begin
    strobes      = '0;
    strobes.step = instValid;
    pushEn       = 1'b0;
    nextSkip     = skipFlag;
    if (instValid) begin
      if (skipFlag) begin
        // suppressed: advance only; a prefix drags its partner along
        nextSkip = isPrefix;
      end else begin
        nextSkip = condSkip;
        case (kind)
          XF_REL_FWD:  strobes.relFwd  = 1'b1;
          XF_REL_BACK: strobes.relBack = 1'b1;
          XF_PAGE:     strobes.pageJmp = 1'b1;
          XF_LONG:     strobes.longJmp = 1'b1;
          XF_TABLE:    strobes.tableJmp = 1'b1;
          XF_CALL_PG: begin
            strobes.pageJmp = 1'b1;
            pushEn          = 1'b1;
          end
          XF_CALL_LG: begin
            strobes.longJmp = 1'b1;
            pushEn          = 1'b1;
          end
          XF_TRAP: begin
            strobes.vector = 1'b1;
            pushEn         = 1'b1;
          end
          XF_RET:      strobes.retLoad = 1'b1;
          XF_RET_SKIP: begin
            strobes.retLoad = 1'b1;
            nextSkip        = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) skipFlag <= 1'b0;
    else       skipFlag <= nextSkip;
  end

endmodule

// File: rtl/pcseq_path.sv
module pcseq_path
  import pcseq_pkg::*;
#(
  parameter int unsigned PC_W     = 15,
  parameter int unsigned PAGE_W   = 12,
  parameter int unsigned TBL_W    = 8,
  parameter int unsigned REL_W    = 5,
  parameter int unsigned LEN_W    = 2,
  parameter logic [PC_W-1:0] VEC_ADDR = 'h00FF,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcStrobes_t       strobes,
  input  logic [LEN_W-1:0] instLen,
  input  logic [REL_W-1:0] relOffset,
  input  logic [PC_W-1:0]  absTarget,
  input  logic [TBL_W-1:0] tableByte,
  input  logic [PC_W-1:0]  retAddr,
  output logic [PC_W-1:0]  pcQ,
  output logic [PC_W-1:0]  seqPc
);

  localparam int unsigned REL_SPAN = 1 << REL_W;

  logic [PC_W-1:0] fwdPc, backPc, pagePc, tablePc, nextPc;

  assign seqPc  = pcQ + PC_W'(instLen);
  assign fwdPc  = seqPc + PC_W'(relOffset);
  assign backPc = seqPc - PC_W'(REL_SPAN) + PC_W'(relOffset);

  generate
    if (PAGE_W >= PC_W) begin : g_flatPage
      assign pagePc = absTarget;
    end else begin : g_splitPage
      assign pagePc = {seqPc[PC_W-1:PAGE_W], absTarget[PAGE_W-1:0]};
    end
    if (TBL_W >= PC_W) begin : g_flatTable
      assign tablePc = PC_W'(tableByte);
    end else begin : g_splitTable
      assign tablePc = {seqPc[PC_W-1:TBL_W], tableByte};
    end
  endgenerate

  always_comb begin
    nextPc = seqPc;
    if (strobes.relFwd)   nextPc = fwdPc;
    if (strobes.relBack)  nextPc = backPc;
    if (strobes.pageJmp)  nextPc = pagePc;
    if (strobes.longJmp)  nextPc = absTarget;
    if (strobes.tableJmp) nextPc = tablePc;
    if (strobes.vector)   nextPc = VEC_ADDR;
    if (strobes.retLoad)  nextPc = retAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pcQ <= RESET_PC;
    else if (strobes.step) pcQ <= nextPc;
  end

endmodule

// File: rtl/pc_skip_seq.sv
module pc_skip_seq
  import pcseq_pkg::*;
#(
  parameter int unsigned PC_W     = 15,
  parameter int unsigned PAGE_W   = 12,
  parameter int unsigned TBL_W    = 8,
  parameter int unsigned REL_W    = 5,
  parameter int unsigned LEN_W    = 2,
  parameter logic [PC_W-1:0] VEC_ADDR = 'h00FF,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [3:0]       xferKind,
  input  logic [LEN_W-1:0] instLen,
  input  logic [REL_W-1:0] relOffset,
  input  logic [PC_W-1:0]  absTarget,
  input  logic [TBL_W-1:0] tableByte,
  input  logic [PC_W-1:0]  retAddr,
  input  logic             condSkip,
  input  logic             isPrefix,
  output logic [PC_W-1:0]  fetchPc,
  output logic [PC_W-1:0]  pushAddr,
  output logic             pushEn,
  output logic             suppress
);

  pcStrobes_t strobes;

  pcseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .xferKind(xferKind),
    .condSkip(condSkip), .isPrefix(isPrefix), .strobes(strobes),
    .pushEn(pushEn), .skipFlag(suppress)
  );

  pcseq_path #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .TBL_W(TBL_W), .REL_W(REL_W),
    .LEN_W(LEN_W), .VEC_ADDR(VEC_ADDR), .RESET_PC(RESET_PC)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instLen(instLen),
    .relOffset(relOffset), .absTarget(absTarget), .tableByte(tableByte),
    .retAddr(retAddr), .pcQ(fetchPc), .seqPc(pushAddr)
  );

endmodule

// File: rtl/pc_skip_seq_chk.sv
module pc_skip_seq_chk #(
  parameter int unsigned PC_W  = 15,
  parameter int unsigned LEN_W = 2,
  parameter logic [PC_W-1:0] VEC_ADDR = 'h00FF,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input logic             clk,
  input logic             rstN,
  input logic             instValid,
  input logic [3:0]       xferKind,
  input logic [LEN_W-1:0] instLen,
  input logic [PC_W-1:0]  absTarget,
  input logic [PC_W-1:0]  retAddr,
  input logic             isPrefix,
  input logic [PC_W-1:0]  fetchPc,
  input logic [PC_W-1:0]  pushAddr,
  input logic             pushEn,
  input logic             suppress
);

  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (fetchPc == RESET_PC && !suppress));

  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> ($stable(fetchPc) && $stable(suppress)));

  a_r10_suppressed_advance: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && suppress) |=>
      fetchPc == PC_W'($past(fetchPc) + PC_W'($past(instLen))));

  a_r10_no_push_when_skipped: assert property (@(posedge clk) disable iff (!rstN)
    suppress |-> !pushEn);

  a_r11_prefix_keeps_skip: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && suppress && isPrefix) |=> suppress);

  a_r6_long_target: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !suppress && xferKind == 4'd4) |=> fetchPc == $past(absTarget));

  a_r8_trap_vector: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !suppress && xferKind == 4'd8) |=> fetchPc == VEC_ADDR);

  a_r8_push_sequential: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |-> pushAddr == PC_W'(fetchPc + PC_W'(instLen)));

  a_r12_return_and_skip: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !suppress && xferKind == 4'd10) |=>
      (suppress && fetchPc == $past(retAddr)));

endmodule

bind pc_skip_seq pc_skip_seq_chk #(
  .PC_W(PC_W), .LEN_W(LEN_W), .VEC_ADDR(VEC_ADDR), .RESET_PC(RESET_PC)
) u_chk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .xferKind(xferKind),
  .instLen(instLen), .absTarget(absTarget), .retAddr(retAddr),
  .isPrefix(isPrefix), .fetchPc(fetchPc), .pushAddr(pushAddr),
  .pushEn(pushEn), .suppress(suppress)
);

// File: tb/pc_skip_seq_bench.sv
module pc_skip_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  xferKind = '0;
  logic [1:0]  instLen = 2'd1;
  logic [4:0]  relOffset = '0;
  logic [14:0] absTarget = '0;
  logic [7:0]  tableByte = '0;
  logic [14:0] retAddr = '0;
  logic        condSkip = 1'b0;
  logic        isPrefix = 1'b0;
  logic [14:0] fetchPc, pushAddr;
  logic        pushEn, suppress;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [14:0] pc;
    logic        sup;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  logic [14:0] mPc = '0;
  logic        mSkip = 1'b0;

  always #4 clk = ~clk;

  pc_skip_seq u_pc_skip_seq (
    .clk(clk), .rstN(rstN), .instValid(instValid), .xferKind(xferKind),
    .instLen(instLen), .relOffset(relOffset), .absTarget(absTarget),
    .tableByte(tableByte), .retAddr(retAddr), .condSkip(condSkip),
    .isPrefix(isPrefix), .fetchPc(fetchPc), .pushAddr(pushAddr),
    .pushEn(pushEn), .suppress(suppress)
  );

  task automatic chk(input string tag, input string what,
                     input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", tag, what, act, exp);
    end
  endtask

  // monitor: compare registered outputs one negedge after each retire edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.tag, "fetchPc", fetchPc, e.pc);
        chk(e.tag, "suppress", 15'(suppress), 15'(e.sup));
      end
    end
  end

  task automatic step(input string tag, input logic v, input logic [3:0] k,
                      input logic [1:0] len, input logic [4:0] off,
                      input logic [14:0] abs, input logic [7:0] tb,
                      input logic [14:0] ra, input logic cs, input logic pf);
    logic [14:0] seq;
    logic        expPush;
    exp_t        e;
    @(negedge clk);
    instValid = v; xferKind = k; instLen = len; relOffset = off;
    absTarget = abs; tableByte = tb; retAddr = ra; condSkip = cs; isPrefix = pf;
    seq = mPc + 15'(len);
    expPush = v && !mSkip && (k == 4'd6 || k == 4'd7 || k == 4'd8);
    #1;
    chk(tag, "pushEn", 15'(pushEn), 15'(expPush));
    if (expPush) chk(tag, "pushAddr", pushAddr, seq);
    if (v) begin
      if (mSkip) begin
        mPc = seq;
        mSkip = pf;
      end else begin
        case (k)
          4'd1:        mPc = seq + 15'(off);
          4'd2:        mPc = seq - 15'd32 + 15'(off);
          4'd3, 4'd6:  mPc = {seq[14:12], abs[11:0]};
          4'd4, 4'd7:  mPc = abs;
          4'd5:        mPc = {seq[14:8], tb};
          4'd8:        mPc = 15'h00FF;
          4'd9, 4'd10: mPc = ra;
          default:     mPc = seq;
        endcase
        mSkip = cs || (k == 4'd10);
      end
    end
    @(posedge clk);
    #1;
    e.pc = mPc; e.sup = mSkip; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "fetchPc", fetchPc, 15'h0000);
    chk("R1", "suppress", 15'(suppress), 15'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "fetchPc after release", fetchPc, 15'h0000);

    step("R2",  1, 4'd0, 2'd2, 5'd0,  15'h0, 8'h0, 15'h0, 0, 0); // 0x0002
    step("R3",  1, 4'd1, 2'd1, 5'd5,  15'h0, 8'h0, 15'h0, 0, 0); // 0x0008
    step("R3",  1, 4'd1, 2'd1, 5'd0,  15'h0, 8'h0, 15'h0, 0, 0); // 0x0009
    step("R4",  1, 4'd2, 2'd1, 5'd0,  15'h0, 8'h0, 15'h0, 0, 0); // wrap 0x7FEA
    step("R4",  1, 4'd2, 2'd1, 5'd31, 15'h0, 8'h0, 15'h0, 0, 0); // 0x7FEA again
    step("R6",  1, 4'd4, 2'd3, 5'd0,  15'h1FFF, 8'h0, 15'h0, 0, 0);
    step("R5",  1, 4'd3, 2'd2, 5'd0,  15'h0234, 8'h0, 15'h0, 0, 0); // 0x2234
    step("R7",  1, 4'd5, 2'd1, 5'd0,  15'h0, 8'h5A, 15'h0, 0, 0);   // 0x225A
    step("R8",  1, 4'd7, 2'd3, 5'd0,  15'h4100, 8'h0, 15'h0, 0, 0); // push 0x225D
    step("R8",  1, 4'd8, 2'd1, 5'd0,  15'h0, 8'h0, 15'h0, 0, 0);    // push 0x4101
    step("R9",  1, 4'd9, 2'd1, 5'd0,  15'h0, 8'h0, 15'h4101, 0, 0);
    step("R10", 1, 4'd0, 2'd2, 5'd0,  15'h0, 8'h0, 15'h0, 1, 0);    // arm skip
    step("R10", 1, 4'd4, 2'd3, 5'd0,  15'h0, 8'h0, 15'h0, 1, 0);    // skipped jump
    step("R10", 1, 4'd0, 2'd1, 5'd0,  15'h0, 8'h0, 15'h0, 1, 0);    // arm skip
    step("R11", 1, 4'd0, 2'd2, 5'd0,  15'h0, 8'h0, 15'h0, 0, 1);    // skipped prefix
    step("R11", 1, 4'd8, 2'd1, 5'd0,  15'h0, 8'h0, 15'h0, 0, 0);    // skipped trap
    step("R12", 1, 4'd10, 2'd1, 5'd0, 15'h0, 8'h0, 15'h3000, 0, 0);
    step("R12", 1, 4'd6, 2'd2, 5'd0,  15'h0777, 8'h0, 15'h0, 0, 0); // skipped call
    step("R13", 0, 4'd4, 2'd3, 5'd0,  15'h5555, 8'h0, 15'h0, 1, 0);
    step("R13", 0, 4'd10, 2'd1, 5'd0, 15'h0, 8'h0, 15'h1234, 0, 0);
    step("R8",  1, 4'd6, 2'd2, 5'd0,  15'h0ABC, 8'h0, 15'h0, 0, 0); // page call
    step("R10", 1, 4'd9, 2'd1, 5'd0,  15'h0, 8'h0, 15'h6000, 1, 0); // ret + cond
    step("R10", 1, 4'd10, 2'd1, 5'd0, 15'h0, 8'h0, 15'h0111, 0, 0); // skipped ret-skip
    step("R2",  1, 4'd11, 2'd3, 5'd0, 15'h0, 8'h0, 15'h0, 0, 0);    // undefined code
    step("R2",  1, 4'd0, 2'd1, 5'd0,  15'h0, 8'h0, 15'h0, 0, 0);

    @(negedge clk);
    instValid = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule